// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command front end of a NOR-style flash array. Each cycle it may take one bus write: a word address and a 16-bit data word. It decodes the unlock-prefixed command sequences that open a 32-word page buffer, fill it and commit it. It also decodes the single-word program command and the sequence that clears an abort. Every rule of the buffered flow is checked as writes arrive. The checks cover the declared load count, the sector chosen by the opening command, the page chosen by the first load and the confirm word that must follow the last load.

On a valid confirm the filled buffer goes to an embedded program engine. The engine holds a word-array model of the flash. It stays busy for a fixed number of cycles and then clears bits in each loaded location: the stored word becomes the old word ANDed with the buffered word. A read port returns the current array contents.

A broken prefix only sends the decoder back to idle. A broken buffered operation latches an abort, and only the abort-clear sequence releases it.

Top module: `flash_wbuf_seq`

## Requirements
- R1: After reset, busy and aborted are 0 and every array word reads 16'hFFFF.
- R2: The writes 16'h00AA at word address 11'h555 (compared on the low 11 address bits), 16'h0055 at 11'h2AA, 16'h0025 at any sector address SA, then N-1 at SA, then N loads, then 16'h0029 at SA, program each loaded location to old AND new. No other location changes. The sector is address bits above bit 8, and the page is address bits above bit 4.
- R3: busy rises on the clock edge that takes the confirm (or the single-word data write) and stays high for exactly PROG_CYCLES cycles. The array updates on the edge where busy falls. Every write taken while busy is ignored.
- R4: The load counter decreases on every load, repeated offsets included. The last data written to an offset is the value programmed.
- R5: A count word above 31 aborts. A count of 31 is accepted.
- R6: An abort is raised by any of these: a count write outside the sector, a first load outside the sector, or a later load outside the page set by the first load.
- R7: After the last counted load, any write other than 16'h0029 inside the sector aborts. This includes a further data load.
- R8: While aborted, every write is ignored, program attempts included. Only 16'h00AA@11'h555, 16'h0055@11'h2AA, 16'h00F0@11'h555 clears the abort and returns to read mode.
- R9: 16'h00AA@11'h555, 16'h0055@11'h2AA, 16'h00A0@11'h555 followed by one write of D at address A programs array[A] to old AND D. No other location changes.
- R10: A write that breaks the unlock or command prefix before the buffer opens returns the decoder to idle without raising aborted. The write that follows it programs nothing.
- R11: An aborted buffered operation changes no array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 16 | Array word at rd_addr (combinational) |
| busy | output | 1 | Embedded program in progress |
| aborted | output | 1 | Buffered operation aborted, waiting for the abort-clear sequence |

## Verification
The bench builds the block with ADDR_W=11, SECT_W=9 and PAGE_W=5, which gives four sectors of sixteen 32-word pages, and with PROG_CYCLES=8. These sizes let a bench-side model of all 2048 words cover the whole array. After each operation the bench reads back the full page affected.

A sweep runs buffered programs of every length from 1 to 32. Each length lands on its own page, with a different starting offset and wrap-around. Each abort rule, the count boundary at 31/32, repeated loads and prefix breaks are then driven one at a time. With eight busy cycles, a whole command sequence can be issued while busy, and its lack of effect can be shown at the read port.

// File: rtl/fwb_pkg.sv
// Shared constants and the decoder state type of the flash buffered-program
// sequencer. Assumes 16-bit bus data and command decode on the low 11 word
// address bits.
package fwb_pkg;
    localparam int WORD_W = 16;
    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] UNL_ADDR_B = 11'h2AA;

    localparam logic [WORD_W-1:0] DAT_UNL_A  = 16'h00AA;
    localparam logic [WORD_W-1:0] DAT_UNL_B  = 16'h0055;
    localparam logic [WORD_W-1:0] DAT_BUFOPN = 16'h0025;
    localparam logic [WORD_W-1:0] DAT_COMMIT = 16'h0029;
    localparam logic [WORD_W-1:0] DAT_SINGLE = 16'h00A0;
    localparam logic [WORD_W-1:0] DAT_CLRABT = 16'h00F0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_BCOUNT,
        ST_BFIRST,
        ST_BLOAD,
        ST_BCOMMIT,
        ST_SDATA,
        ST_ABT,
        ST_ABT_UNL1,
        ST_ABT_UNL2
    } seq_state_t;
endpackage

// File: rtl/fwb_cmd_fsm.sv
// Command decoder: walks the unlock prefix and the buffered / single-word
// program sequences, checks sector, page, count and commit rules, and drives
// buffer loads and the program start. Assumes ADDR_W >= CMD_AW and
// SECT_W >= PAGE_W. Writes are dropped while the engine is busy.
module fwb_cmd_fsm
    import fwb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SECT_W = 9,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     eng_busy,
    output logic                     buf_clr,
    output logic                     buf_ld,
    output logic [PAGE_W-1:0]        buf_off,
    output logic                     prog_start,
    output logic [ADDR_W-PAGE_W-1:0] prog_page,
    output logic                     aborted
);
    localparam int SECT_IW  = ADDR_W - SECT_W;
    localparam int PAGE_IW  = ADDR_W - PAGE_W;
    localparam int BUF_LAST = (1 << PAGE_W) - 1;

    seq_state_t          st_q, st_d;
    logic [SECT_IW-1:0]  sect_q;
    logic [PAGE_IW-1:0]  page_q;
    logic [PAGE_W-1:0]   rem_q;
    logic take, sect_ok, page_ok, is_unl_a, is_unl_b, is_clr, cnt_bad;
    logic set_sect, set_page, set_rem, dec_rem;

    // Decode the current bus write against the held sector and page.
    always_comb begin
        take     = wr_en && !eng_busy;
        sect_ok  = wr_addr[ADDR_W-1:SECT_W] == sect_q;
        page_ok  = wr_addr[ADDR_W-1:PAGE_W] == page_q;
        is_unl_a = wr_addr[CMD_AW-1:0] == UNL_ADDR_A && wr_data == DAT_UNL_A;
        is_unl_b = wr_addr[CMD_AW-1:0] == UNL_ADDR_B && wr_data == DAT_UNL_B;
        is_clr   = wr_addr[CMD_AW-1:0] == UNL_ADDR_A && wr_data == DAT_CLRABT;
        cnt_bad  = wr_data > WORD_W'(BUF_LAST);
        buf_off  = wr_addr[PAGE_W-1:0];
        prog_page = (st_q == ST_SDATA) ? wr_addr[ADDR_W-1:PAGE_W] : page_q;
        aborted  = st_q == ST_ABT || st_q == ST_ABT_UNL1 || st_q == ST_ABT_UNL2;
    end

    // Next-state and control-strobe logic for one accepted write.
    always_comb begin
        st_d = st_q;
        buf_clr = 1'b0; buf_ld = 1'b0; prog_start = 1'b0;
        set_sect = 1'b0; set_page = 1'b0; set_rem = 1'b0; dec_rem = 1'b0;
        if (take) begin
            case (st_q)
                ST_IDLE:   st_d = is_unl_a ? ST_UNL1 : ST_IDLE;
                ST_UNL1:   st_d = is_unl_b ? ST_UNL2 : ST_IDLE;
                ST_UNL2: begin
                    if (wr_data == DAT_BUFOPN) begin
                        st_d = ST_BCOUNT;
                        set_sect = 1'b1;
                    end else if (wr_data == DAT_SINGLE &&
                                 wr_addr[CMD_AW-1:0] == UNL_ADDR_A) begin
                        st_d = ST_SDATA;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_BCOUNT: begin
                    if (!sect_ok || cnt_bad) begin
                        st_d = ST_ABT;
                    end else begin
                        st_d = ST_BFIRST;
                        set_rem = 1'b1;
                        buf_clr = 1'b1;
                    end
                end
                ST_BFIRST: begin
                    if (!sect_ok) begin
                        st_d = ST_ABT;
                    end else begin
                        set_page = 1'b1;
                        buf_ld = 1'b1;
                        dec_rem = 1'b1;
                        st_d = (rem_q == '0) ? ST_BCOMMIT : ST_BLOAD;
                    end
                end
                ST_BLOAD: begin
                    if (!page_ok) begin
                        st_d = ST_ABT;
                    end else begin
                        buf_ld = 1'b1;
                        dec_rem = 1'b1;
                        st_d = (rem_q == '0) ? ST_BCOMMIT : ST_BLOAD;
                    end
                end
                ST_BCOMMIT: begin
                    if (sect_ok && wr_data == DAT_COMMIT) begin
                        prog_start = 1'b1;
                        st_d = ST_IDLE;
                    end else begin
                        st_d = ST_ABT;
                    end
                end
                ST_SDATA: begin
                    buf_clr = 1'b1;
                    buf_ld = 1'b1;
                    prog_start = 1'b1;
                    st_d = ST_IDLE;
                end
                ST_ABT:      st_d = is_unl_a ? ST_ABT_UNL1 : ST_ABT;
                ST_ABT_UNL1: st_d = is_unl_b ? ST_ABT_UNL2 : ST_ABT;
                ST_ABT_UNL2: st_d = is_clr   ? ST_IDLE     : ST_ABT;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // State, held sector/page and remaining-load counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sect_q <= '0;
            page_q <= '0;
            rem_q  <= '0;
        end else begin
            st_q <= st_d;
            if (set_sect) sect_q <= wr_addr[ADDR_W-1:SECT_W];
            if (set_page) page_q <= wr_addr[ADDR_W-1:PAGE_W];
            if (set_rem)  rem_q  <= wr_data[PAGE_W-1:0];
            else if (dec_rem && rem_q != '0) rem_q <= rem_q - 1'b1;
        end
    end
endmodule

// File: rtl/fwb_page_buf.sv
// Page buffer: one data word and one loaded flag per page offset. A clear and
// a load in the same cycle leave only the loaded offset marked. Assumes the
// decoder never clears or loads while the engine is reading the buffer.
module fwb_page_buf
    import fwb_pkg::*;
#(
    parameter int PAGE_W = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 ld,
    input  logic [PAGE_W-1:0]                    off,
    input  logic [WORD_W-1:0]                    din,
    output logic [(1<<PAGE_W)-1:0][WORD_W-1:0]   data_q,
    output logic [(1<<PAGE_W)-1:0]               vld_q
);
    localparam int NWORDS = 1 << PAGE_W;

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        logic hit;
        assign hit = ld && off == PAGE_W'(g);

        // Per-offset slot: the last load wins, clear drops the flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else if (hit) begin
                data_q[g] <= din;
                vld_q[g]  <= 1'b1;
            end else if (clr) begin
                vld_q[g]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fwb_prog_engine.sv
// Embedded program engine and word-array model. On start it latches the page,
// stays busy for PROG_CYCLES cycles, then ANDs every loaded buffer word into
// its array location on the edge where busy falls. Erased state is all ones.
module fwb_prog_engine
    import fwb_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [ADDR_W-PAGE_W-1:0]             page,
    input  logic [(1<<PAGE_W)-1:0][WORD_W-1:0]   buf_data,
    input  logic [(1<<PAGE_W)-1:0]               buf_vld,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [WORD_W-1:0]                    rd_data,
    output logic                                 busy
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NWORDS = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

    logic [WORD_W-1:0]        mem [DEPTH];
    logic [CNT_W-1:0]         cnt_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;

    // Busy timer and the final bit-clearing commit into the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
            page_q <= page;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
                for (int i = 0; i < NWORDS; i++) begin
                    if (buf_vld[i])
                        mem[{page_q, PAGE_W'(i)}] <= mem[{page_q, PAGE_W'(i)}] & buf_data[i];
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_wbuf_seq.sv
// Top of the flash buffered-program command sequencer: decoder, page buffer
// and program engine. Assumes one bus write per cycle and ADDR_W >= 11.
module flash_wbuf_seq
    import fwb_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SECT_W      = 9,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              aborted
);
    localparam int NWORDS  = 1 << PAGE_W;
    localparam int PAGE_IW = ADDR_W - PAGE_W;

    logic                             buf_clr, buf_ld, prog_start;
    logic [PAGE_W-1:0]                buf_off;
    logic [PAGE_IW-1:0]               prog_page;
    logic [NWORDS-1:0][WORD_W-1:0]    buf_data;
    logic [NWORDS-1:0]                buf_vld;

    fwb_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(busy), .buf_clr(buf_clr), .buf_ld(buf_ld),
        .buf_off(buf_off), .prog_start(prog_start), .prog_page(prog_page),
        .aborted(aborted)
    );

    fwb_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .ld(buf_ld), .off(buf_off),
        .din(wr_data), .data_q(buf_data), .vld_q(buf_vld)
    );

    fwb_prog_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .page(prog_page),
        .buf_data(buf_data), .buf_vld(buf_vld), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: rtl/fwb_checker.sv
// Port-level property checker for flash_wbuf_seq, attached by bind below.
// Tracks the length of each busy run with a counter.
module fwb_checker
    import fwb_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       rd_data,
    input logic              busy,
    input logic              aborted
);
    logic [31:0] run_q;

    // Count consecutive busy cycles already elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 1 : '0;
    end

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < PROG_CYCLES);

    p_busy_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(run_q) == PROG_CYCLES - 1);

    p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en) && !$past(aborted));

    p_abort_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> !busy);

    p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aborted && !(wr_en && wr_addr[CMD_AW-1:0] == UNL_ADDR_A && wr_data == DAT_CLRABT)
        |=> aborted);

    p_array_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_addr) && !$fell(busy) |-> $stable(rd_data));
endmodule

bind flash_wbuf_seq fwb_checker #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .aborted(aborted)
);

// File: tb/flash_wbuf_seq_test.sv
module flash_wbuf_seq_test;
    localparam int AW = 11;
    localparam int SW = 9;
    localparam int PW = 5;
    localparam int PC = 8;
    localparam int NW = 1 << PW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy, aborted;

    int vectors = 0;
    int fails = 0;
    logic [15:0]      model [DEPTH];
    logic [15:0]      pend_d [NW];
    logic             pend_v [NW];
    logic [AW-PW-1:0] pend_pg;

    always #2 clk = ~clk;

    flash_wbuf_seq #(.ADDR_W(AW), .SECT_W(SW), .PAGE_W(PW), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .aborted(aborted)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic abort_clear();
        unlock();
        wr(11'h555, 16'h00F0);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic verify_word(input logic [AW-1:0] a, input string tag);
        rd_addr = a;
        #1;
        check_eq(tag, 32'(rd_data), 32'(model[a]));
    endtask

    task automatic verify_page(input logic [AW-PW-1:0] pg, input string tag);
        for (int i = 0; i < NW; i++) verify_word({pg, PW'(i)}, tag);
    endtask

    task automatic wait_prog(input string tag);
        int n;
        n = 0;
        check_eq({tag, " busy after start"}, 32'(busy), 32'd1);
        while (busy && n < PC + 4) begin
            @(negedge clk);
            n++;
        end
        check_eq({tag, " busy length"}, n, PC);
    endtask

    task automatic begin_wbuf(input logic [AW-1:0] sa, input logic [15:0] cnt);
        for (int i = 0; i < NW; i++) pend_v[i] = 1'b0;
        unlock();
        wr(sa, 16'h0025);
        wr(sa, cnt);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [15:0] d);
        wr(a, d);
        pend_d[a[PW-1:0]] = d;
        pend_v[a[PW-1:0]] = 1'b1;
        pend_pg = a[AW-1:PW];
    endtask

    task automatic commit(input logic [AW-1:0] sa, input string tag);
        wr(sa, 16'h0029);
        wait_prog(tag);
        for (int i = 0; i < NW; i++)
            if (pend_v[i]) model[{pend_pg, PW'(i)}] = model[{pend_pg, PW'(i)}] & pend_d[i];
    endtask

    task automatic expect_abort(input string tag);
        check_eq({tag, " aborted"}, 32'(aborted), 32'd1);
        check_eq({tag, " not busy"}, 32'(busy), 32'd0);
        abort_clear();
        check_eq({tag, " abort cleared"}, 32'(aborted), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [5:0]    pg;
        logic [AW-1:0] sa, a;
        logic [15:0]   d;
        int            st;

        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        idle_cycles(4);
        rst_n = 1'b1;
        idle_cycles(1);

        // R1: reset state, whole array erased
        check_eq("R1 busy", 32'(busy), 32'd0);
        check_eq("R1 aborted", 32'(aborted), 32'd0);
        for (int i = 0; i < DEPTH; i++) verify_word(AW'(i), "R1 erased");

        // R2: every buffer length 1..32, varied page, start offset and wrap
        for (int n = 1; n <= NW; n++) begin
            pg = 6'((n * 5) % 64);
            sa = {pg[5:4], 9'((n * 13) % 512)};
            st = (n * 7) % NW;
            begin_wbuf(sa, 16'(n - 1));
            for (int k = 0; k < n; k++) begin
                d = 16'hFFFF ^ (16'h0001 << ((n + k) % 16)) ^ (16'h0101 << (k % 8));
                load({pg, PW'((st + k) % NW)}, d);
            end
            commit(sa, "R2");
            check_eq("R2 no abort", 32'(aborted), 32'd0);
            verify_page(pg, "R2 page");
        end

        // R4: repeated offsets count as loads, last data wins
        sa = {2'd3, 9'h1F0};
        begin_wbuf(sa, 16'd5);
        load({6'd63, 5'd3}, 16'hF0F0);
        load({6'd63, 5'd7}, 16'hAAAA);
        load({6'd63, 5'd3}, 16'h1234);
        load({6'd63, 5'd3}, 16'h0FF0);
        load({6'd63, 5'd7}, 16'h5555);
        load({6'd63, 5'd9}, 16'h00FF);
        commit(sa, "R4");
        check_eq("R4 no abort", 32'(aborted), 32'd0);
        verify_page(6'd63, "R4 page");
        // R4/R7: count 1 with the same offset twice; a third load aborts
        begin_wbuf(sa, 16'd1);
        load({6'd63, 5'd20}, 16'h0000);
        load({6'd63, 5'd20}, 16'h0000);
        wr({6'd63, 5'd20}, 16'h0000);
        expect_abort("R4 extra load");
        verify_page(6'd63, "R4 extra load page");

        // R5: count above 31 aborts; R8 writes while aborted are ignored
        sa = {2'd3, 9'h1C0};
        begin_wbuf(sa, 16'h0020);
        check_eq("R5 count 32 aborts", 32'(aborted), 32'd1);
        wr({6'd62, 5'd1}, 16'h0000);
        wr(sa, 16'h0029);
        unlock();
        wr(11'h555, 16'h00A0);
        wr({6'd62, 5'd2}, 16'h0000);
        idle_cycles(PC + 2);
        check_eq("R8 no program while aborted", 32'(busy), 32'd0);
        check_eq("R8 still aborted", 32'(aborted), 32'd1);
        verify_page(6'd62, "R8 page");
        expect_abort("R8 clear");
        begin_wbuf(sa, 16'h0100);
        expect_abort("R5 count 256");
        begin_wbuf(sa, 16'd31);
        check_eq("R5 count 31 accepted", 32'(aborted), 32'd0);
        // R6: first load in another sector
        wr({6'd2, 5'd4}, 16'h0000);
        expect_abort("R6 first load sector");
        verify_page(6'd2, "R11 page");
        verify_page(6'd62, "R11 page");

        // R6: later load outside the page
        sa = {2'd3, 9'h1A0};
        begin_wbuf(sa, 16'd3);
        load({6'd61, 5'd2}, 16'h0000);
        wr({6'd60, 5'd2}, 16'h0000);
        expect_abort("R6 page change");
        verify_page(6'd61, "R11 page");
        verify_page(6'd60, "R11 page");
        // R6: count written to another sector
        unlock();
        wr(sa, 16'h0025);
        wr({2'd1, 9'h1A0}, 16'd3);
        expect_abort("R6 count sector");
        // R6: later load in another sector
        begin_wbuf(sa, 16'd3);
        load({6'd61, 5'd2}, 16'h0000);
        wr({6'd29, 5'd2}, 16'h0000);
        expect_abort("R6 load sector");
        verify_page(6'd29, "R11 page");
        verify_page(6'd61, "R11 page");

        // R7: commit word in another sector, wrong commit word
        begin_wbuf(sa, 16'd1);
        load({6'd61, 5'd5}, 16'h0000);
        load({6'd61, 5'd6}, 16'h0000);
        wr({2'd0, 9'h1A0}, 16'h0029);
        expect_abort("R7 commit sector");
        begin_wbuf(sa, 16'd0);
        load({6'd61, 5'd5}, 16'h0000);
        wr(sa, 16'h0030);
        expect_abort("R7 commit word");
        verify_page(6'd61, "R11 page");

        // R9: single-word program, including a word already programmed
        for (int j = 0; j < 6; j++) begin
            a = AW'((j * 389 + 165) % DEPTH);
            d = ~(16'h0003 << (j * 2));
            unlock();
            wr(11'h555, 16'h00A0);
            wr(a, d);
            wait_prog("R9");
            model[a] = model[a] & d;
            verify_word(a, "R9 word");
            verify_word(a ^ 11'h001, "R9 neighbour");
        end

        // R10: broken prefixes go idle quietly and the next write does nothing
        a = 11'h4C3;
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0056);
        check_eq("R10 break at unlock 2", 32'(aborted), 32'd0);
        wr(a, 16'h0000);
        idle_cycles(PC + 2);
        check_eq("R10 no busy", 32'(busy), 32'd0);
        verify_word(a, "R10 word");
        unlock();
        wr(11'h555, 16'h0077);
        check_eq("R10 break at command", 32'(aborted), 32'd0);
        wr(a, 16'h0000);
        unlock();
        wr(11'h123, 16'h00A0);
        wr(a, 16'h0000);
        idle_cycles(PC + 2);
        check_eq("R10 no busy after bad command", 32'(busy), 32'd0);
        check_eq("R10 no abort", 32'(aborted), 32'd0);
        verify_word(a, "R10 word");

        // R3: a whole command sequence issued while busy is dropped
        a = 11'h0F1;
        unlock();
        wr(11'h555, 16'h00A0);
        wr(a, 16'h00FF);
        check_eq("R3 busy after data", 32'(busy), 32'd1);
        unlock();
        wr(11'h555, 16'h00A0);
        while (busy) @(negedge clk);
        model[a] = model[a] & 16'h00FF;
        wr(11'h0F2, 16'h0000);
        idle_cycles(PC + 2);
        check_eq("R3 ignored sequence", 32'(busy), 32'd0);
        verify_word(a, "R3 word");
        verify_word(11'h0F2, "R3 ignored word");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule